// File: doc/BRIEF.md
# Authorized Copy Commit Controller

This block carries out the scratchpad-to-memory copy command of a byte-oriented serial memory device. The byte-level bus interface passes in received bytes one at a time. When the first byte after a bus reset is the copy command code, the block gathers the next three bytes as an authorization echo. It compares them, one by one, with the stored target-address and ending-offset/status registers. It then checks the target range, the partial-byte flag and the copy-protection input.

When every check passes, the block sets its authorization-accepted flag and enters a timed busy phase. At the start of that phase it reads the selected scratchpad bytes one per cycle and writes them to memory in ascending address order. The busy phase lasts a fixed number of cycles given by a parameter, which models the programming time. After it ends, every byte the host reads is the confirmation value AAh, until the next bus reset. A failed or foreign command leaves memory untouched, and the host then reads FFh.

Top module: `ccc_copy_ctrl`

## Requirements
- R1: After a bus reset, a first byte of 55h starts the command. The next three bytes must equal, in this order, `ta[7:0]`, `ta[15:8]` and the whole `es` byte. A mismatch in any one of them rejects the command.
- R2: The command is accepted only when all four of these hold:
  - the pattern matches;
  - `ta` is below MEM_BYTES;
  - the ending offset `es[4:0]` is not below the start offset `ta[4:0]`;
  - the partial flag `es[5]` is clear and `prot` is low.
  On acceptance, `aa_flag` is 1 and `busy` is 1 from the next cycle.
- R3: A rejected command clears `aa_flag`, issues no `mem_we`, and leaves `rd_byte` at FFh until a bus reset.
- R4: An accepted copy issues `es[4:0]-ta[4:0]+1` write strobes on consecutive cycles, starting in the first busy cycle. The first address is `ta[ADDR_W-1:0]` and each later address is one higher. Data for the k-th write is the scratchpad byte at offset `ta[4:0]+k`.
- R5: `busy` stays high for exactly BUSY_CYCLES cycles per accepted copy, whatever the byte count.
- R6: `rd_byte` is FFh while idle, while collecting the pattern and while busy.
- R7: From the cycle after the busy phase ends, `rd_byte` is AAh until `bus_rst` is seen. After that it is FFh and a new command can start.
- R8: A `bus_rst` while the pattern is being collected aborts the command. It leaves `aa_flag` unchanged, issues no write, and the next byte is taken as a new command.
- R9: A `bus_rst` during the busy phase does not shorten the phase or stop the writes. When the phase ends, the block returns to idle with `rd_byte` at FFh instead of confirming.
- R10: A first byte other than 55h is ignored with no writes and no change to `aa_flag`. `rd_byte` stays FFh and later bytes are ignored until a bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Bus reset pulse from the bus interface |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| ta | input | 16 | Stored target address register |
| es | input | 8 | Stored ending-offset/status register (bit 5 partial flag, bits 4:0 ending offset) |
| prot | input | 1 | Target memory is copy-protected |
| sp_addr | output | 5 | Scratchpad read offset |
| sp_data | input | 8 | Scratchpad byte at `sp_addr` (combinational read) |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| busy | output | 1 | Programming phase in progress |
| aa_flag | output | 1 | Authorization accepted flag |
| rd_byte | output | 8 | Byte the host receives on a read slot |

## Verification
The assertions assume three things about the inputs:
- each received byte arrives as a single-cycle `rx_valid` pulse;
- `ta`, `es` and `prot` are steady in the cycle that carries the third pattern byte, which is the only cycle in which the copy parameters are captured;
- the scratchpad answers `sp_addr` within the same cycle.

The bench drives bytes only on falling edges, one cycle apart, and holds the register inputs constant for the whole command. It sweeps every start/end offset pair over several pages. It also runs each rejection cause on its own and places bus resets inside the pattern and inside the busy phase.

// File: rtl/ccc_pkg.sv
package ccc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AUTH,
    ST_BUSY,
    ST_DONE,
    ST_DEAD
  } ccc_state_e;

  localparam logic [7:0] CMD_COPY  = 8'h55;
  localparam logic [7:0] CONFIRM   = 8'hAA;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  // number of bytes moved for a start/end offset pair (1..32)
  function automatic logic [5:0] span_len(input logic [4:0] s, input logic [4:0] e);
    return {1'b0, e} - {1'b0, s} + 6'd1;
  endfunction

  // target inside memory and ending offset not before start offset
  function automatic logic range_ok(input logic [15:0] t, input logic [4:0] e,
                                    input int unsigned mem_bytes);
    return (32'(t) < mem_bytes) && (e >= t[4:0]);
  endfunction

endpackage

// File: rtl/ccc_auth.sv
module ccc_auth
  import ccc_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_rst,
  input  logic        arm,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic [15:0] ta,
  input  logic [7:0]  es,
  input  logic        prot,
  output logic        fin,
  output logic        pass
);

  logic [1:0] idx;
  logic       miss;
  logic       take;
  logic [7:0] expect_byte;

  assign take = arm && rx_valid && !bus_rst;

  always_comb begin
    unique case (idx)
      2'd0:    expect_byte = ta[7:0];
      2'd1:    expect_byte = ta[15:8];
      default: expect_byte = es;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= 2'd0;
      miss <= 1'b0;
    end else if (bus_rst || !arm) begin
      idx  <= 2'd0;
      miss <= 1'b0;
    end else if (take) begin
      idx  <= idx + 2'd1;
      miss <= miss | (rx_byte != expect_byte);
    end
  end

  assign fin  = take && (idx == 2'd2);
  assign pass = fin && !miss && (rx_byte == es) &&
                range_ok(ta, es[4:0], MEM_BYTES) && !es[5] && !prot;

endmodule

// File: rtl/ccc_xfer.sv
module ccc_xfer
  import ccc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned BUSY_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [4:0]        end_off,
  output logic [4:0]        sp_addr,
  input  logic [7:0]        sp_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              done
);

  localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);

  logic              run;
  logic [CW-1:0]     cyc;
  logic [ADDR_W-1:0] base;
  logic [5:0]        len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      cyc  <= '0;
      base <= '0;
      len  <= '0;
    end else if (start) begin
      run  <= 1'b1;
      cyc  <= '0;
      base <= base_in;
      len  <= span_len(base_in[4:0], end_off);
    end else if (done) begin
      run <= 1'b0;
      cyc <= '0;
    end else if (run) begin
      cyc <= cyc + 1'b1;
    end
  end

  assign busy      = run;
  assign done      = run && (cyc == CW'(BUSY_CYCLES - 1));
  assign mem_we    = run && (32'(cyc) < 32'(len));
  assign mem_addr  = base + ADDR_W'(cyc);
  assign sp_addr   = base[4:0] + cyc[4:0];
  assign mem_wdata = sp_data;

endmodule

// File: rtl/ccc_copy_ctrl.sv
module ccc_copy_ctrl
  import ccc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned MEM_BYTES   = 512,
  parameter int unsigned BUSY_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic [15:0]       ta,
  input  logic [7:0]        es,
  input  logic              prot,
  output logic [4:0]        sp_addr,
  input  logic [7:0]        sp_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              aa_flag,
  output logic [7:0]        rd_byte
);

  ccc_state_e state;
  logic       rst_pend;
  logic       auth_fin;
  logic       auth_pass;
  logic       accept;
  logic       reject;
  logic       xfer_done;
  logic       cmd_take;

  ccc_auth #(.MEM_BYTES(MEM_BYTES)) u_auth (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rst  (bus_rst),
    .arm      (state == ST_AUTH),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .ta       (ta),
    .es       (es),
    .prot     (prot),
    .fin      (auth_fin),
    .pass     (auth_pass)
  );

  ccc_xfer #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .base_in   (ta[ADDR_W-1:0]),
    .end_off   (es[4:0]),
    .sp_addr   (sp_addr),
    .sp_data   (sp_data),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (xfer_done)
  );

  assign accept   = auth_pass;
  assign reject   = auth_fin && !auth_pass;
  assign cmd_take = (state == ST_IDLE) && rx_valid && !bus_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rst_pend <= 1'b0;
      aa_flag  <= 1'b0;
    end else begin
      if (accept)      aa_flag <= 1'b1;
      else if (reject) aa_flag <= 1'b0;

      unique case (state)
        ST_IDLE: if (cmd_take) state <= (rx_byte == CMD_COPY) ? ST_AUTH : ST_DEAD;
        ST_AUTH: begin
          if (bus_rst)     state <= ST_IDLE;
          else if (accept) state <= ST_BUSY;
          else if (reject) state <= ST_DEAD;
        end
        ST_BUSY: begin
          if (xfer_done) begin
            state    <= (rst_pend || bus_rst) ? ST_IDLE : ST_DONE;
            rst_pend <= 1'b0;
          end else if (bus_rst) begin
            rst_pend <= 1'b1;
          end
        end
        ST_DONE, ST_DEAD: if (bus_rst) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_byte = (state == ST_DONE) ? CONFIRM : IDLE_BYTE;

endmodule

// File: rtl/ccc_copy_ctrl_chk.sv
module ccc_copy_ctrl_chk #(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned BUSY_CYCLES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rst,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              aa_flag,
  input logic [7:0]        rd_byte,
  input logic              accept,
  input logic              reject,
  input logic              xfer_done,
  input logic              rst_pend
);

  int unsigned bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= 0;
  end

  p_accept_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && aa_flag);

  p_reject_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> !busy && !aa_flag && rd_byte == 8'hFF);

  p_we_inside_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we) |-> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bcnt == BUSY_CYCLES);

  p_ff_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rd_byte == 8'hFF);

  p_confirm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !rst_pend && !bus_rst |=> rd_byte == 8'hAA);

  p_pend_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && rst_pend |=> rd_byte == 8'hFF && !busy);

endmodule

bind ccc_copy_ctrl ccc_copy_ctrl_chk #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rst   (bus_rst),
  .busy      (busy),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .aa_flag   (aa_flag),
  .rd_byte   (rd_byte),
  .accept    (accept),
  .reject    (reject),
  .xfer_done (xfer_done),
  .rst_pend  (rst_pend)
);

// File: tb/sim_ccc_copy_ctrl.sv
`timescale 1ns/1ps
module sim_ccc_copy_ctrl;

  localparam int AW  = 7;
  localparam int MB  = 128;
  localparam int BC  = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_rst = 1'b0;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_byte = 8'h00;
  logic [15:0]   ta = 16'h0000;
  logic [7:0]    es = 8'h00;
  logic          prot = 1'b0;
  logic [4:0]    sp_addr;
  logic [7:0]    sp_data;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          busy;
  logic          aa_flag;
  logic [7:0]    rd_byte;

  int   total = 0;
  int   fails = 0;
  logic [7:0] seed = 8'h00;
  logic [7:0] mem [MB];
  int   wr_n = 0;
  int   ord_err = 0;
  int   first_a = -1;
  int   last_a = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] sp_fn(input int off, input logic [7:0] sd);
    return 8'(off * 5 + 1) ^ sd;
  endfunction

  assign sp_data = sp_fn(int'(sp_addr), seed);

  ccc_copy_ctrl #(.ADDR_W(AW), .MEM_BYTES(MB), .BUSY_CYCLES(BC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .ta(ta), .es(es), .prot(prot), .sp_addr(sp_addr),
    .sp_data(sp_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .aa_flag(aa_flag), .rd_byte(rd_byte)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      if (wr_n == 0) first_a = int'(mem_addr);
      else if (int'(mem_addr) != last_a + 1) ord_err++;
      last_a = int'(mem_addr);
      mem[mem_addr] = mem_wdata;
      wr_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic brst();
    bus_rst = 1'b1;
    @(negedge clk);
    bus_rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_mon();
    for (int i = 0; i < MB; i++) mem[i] = 8'h00;
    wr_n = 0; ord_err = 0; first_a = -1;
  endtask

  // full good copy from start offset s to end offset e on a page
  task automatic good_copy(input int s, input int e, input int page, input bit burst_rst);
    int cnt;
    int bad;
    brst();
    clear_mon();
    seed = 8'(s * 3 + e);
    ta = 16'(page * 32 + s);
    es = {3'b000, 5'(e)};
    prot = 1'b0;
    send(8'h55); send(ta[7:0]); send(ta[15:8]); send(es);
    chk(busy == 1'b1 && aa_flag == 1'b1, "R2 accept", {busy, aa_flag}, 3);
    chk(rd_byte == 8'hFF, "R6 busy read", rd_byte, 8'hFF);
    cnt = 0;
    while (busy && cnt < BC + 10) begin
      if (burst_rst && cnt == 3) bus_rst = 1'b1;
      cnt++;
      @(negedge clk);
      bus_rst = 1'b0;
    end
    chk(cnt == BC, "R5 busy length", cnt, BC);
    bad = 0;
    for (int i = 0; i < 32; i++) begin
      logic [7:0] exp;
      exp = (i >= s && i <= e) ? sp_fn(i, seed) : 8'h00;
      if (mem[page * 32 + i] != exp) bad++;
    end
    chk(bad == 0 && wr_n == e - s + 1 && ord_err == 0 && first_a == page * 32 + s,
        "R4 written range", wr_n, e - s + 1);
    if (burst_rst) chk(rd_byte == 8'hFF, "R9 idle after reset in busy", rd_byte, 8'hFF);
    else           chk(rd_byte == 8'hAA, "R7 confirm", rd_byte, 8'hAA);
  endtask

  // command that must be turned down; checks no writes, flag clear, FF reads
  task automatic reject_case(input string req, input logic [15:0] t, input logic [7:0] s_es,
                             input bit p, input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2);
    brst();
    clear_mon();
    ta = t; es = s_es; prot = p;
    send(8'h55); send(b0); send(b1); send(b2);
    repeat (BC + 4) @(negedge clk);
    chk(!aa_flag && !busy && wr_n == 0, {req, " R3 rejected"}, wr_n, 0);
    send(8'h55);
    chk(rd_byte == 8'hFF && !busy, {req, " R3 reads FF"}, rd_byte, 8'hFF);
    prot = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !aa_flag && !mem_we && rd_byte == 8'hFF, "R6 reset state",
        {busy, aa_flag, mem_we}, 0);

    // R4 R5 R7: every start/end pair over rotating pages
    for (int s = 0; s < 32; s++)
      for (int e = s; e < 32; e++)
        good_copy(s, e, (s + e) % 4, 1'b0);

    // R7: confirmation held until bus reset, then FF
    repeat (5) @(negedge clk);
    chk(rd_byte == 8'hAA, "R7 held", rd_byte, 8'hAA);
    brst();
    chk(rd_byte == 8'hFF, "R7 after bus reset", rd_byte, 8'hFF);

    // R1 each pattern byte wrong
    reject_case("R1 byte0", 16'h0023, 8'h1F, 1'b0, 8'h22, 8'h00, 8'h1F);
    reject_case("R1 byte1", 16'h0023, 8'h1F, 1'b0, 8'h23, 8'h01, 8'h1F);
    reject_case("R1 byte2", 16'h0023, 8'h1F, 1'b0, 8'h23, 8'h00, 8'h1E);
    // R2 individual conditions
    reject_case("R2 partial", 16'h0023, 8'h3F, 1'b0, 8'h23, 8'h00, 8'h3F);
    reject_case("R2 protect", 16'h0023, 8'h1F, 1'b1, 8'h23, 8'h00, 8'h1F);
    reject_case("R2 range", 16'h0080, 8'h1F, 1'b0, 8'h80, 8'h00, 8'h1F);
    reject_case("R2 high", 16'h0100, 8'h1F, 1'b0, 8'h00, 8'h01, 8'h1F);
    reject_case("R2 order", 16'h0025, 8'h04, 1'b0, 8'h25, 8'h00, 8'h04);

    // R8: abort during pattern with flag set keeps flag and writes nothing
    good_copy(2, 9, 1, 1'b0);
    brst();
    clear_mon();
    send(8'h55); send(ta[7:0]);
    bus_rst = 1'b1; @(negedge clk); bus_rst = 1'b0;
    send(ta[15:8]); send(es);
    repeat (BC + 4) @(negedge clk);
    chk(aa_flag && !busy && wr_n == 0, "R8 abort keeps flag", {aa_flag, busy}, 2);
    good_copy(4, 6, 2, 1'b0);
    chk(aa_flag, "R8 new command after abort", aa_flag, 1);

    // R9: bus reset during busy
    good_copy(0, 31, 3, 1'b1);
    good_copy(1, 1, 0, 1'b0);
    chk(rd_byte == 8'hAA, "R9 idle reached, next copy ok", rd_byte, 8'hAA);

    // R10: foreign command
    brst();
    clear_mon();
    ta = 16'h0041; es = 8'h05;
    send(8'hAA); send(8'h55); send(8'h41); send(8'h00); send(8'h05);
    repeat (BC + 4) @(negedge clk);
    chk(aa_flag && !busy && wr_n == 0 && rd_byte == 8'hFF, "R10 foreign ignored",
        wr_n, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule